// File: doc/BRIEF.md
# Half-Integer Predivider Clock Generator

This block derives a programmable master clock, for a display pixel clock or an audio master clock, from one of three source clocks. A two-stage divide chain sets the output rate. The first stage divides by 2, 2.5 or 3. The second stage divides by an integer. The design runs on one fast system clock. Each source arrives as a tick strobe, and every tick stands for one half-period of that source, so the ticks run at twice the source rate. Because the fast side counts half-periods, a 2.5 predivision is just a count of five ticks.

The block takes settings from a control register that sits elsewhere: an enable bit, a 2-bit predivide code, a 7-bit integer divide code and two source-select bits. It copies these settings into an internal configuration only when the output is idle or at the end of a complete output period. A retune or a source switch therefore never cuts a phase short. The output rate is twice the source rate divided by (predivide code + 3) times the divide code. The valid flag is high whenever the accepted configuration produces a clock.

Top module: `hipd_clkgen`

## Requirements
- R1: While reset is asserted, and after it until a usable setting is presented, `clk_out` and `out_valid` are 0. Reset clears the accepted enable, both codes and both select bits, which selects the crystal source.
- R2: With an accepted setting, one output period lasts (pre_code + 3) × div_code ticks of the selected source. Codes 1, 2 and 3 give 4, 5 and 6 ticks per predivided step, which is 2, 2.5 and 3 source periods.
- R3: Each period starts with a high phase of (pre_code + 3) × floor(div_code / 2) ticks and is low for the remaining ticks.
- R4: A predivide code of 0 produces no clock: `clk_out` stays 0 and `out_valid` is 0.
- R5: A divide code of 0 or 1 produces no clock: `clk_out` stays 0 and `out_valid` is 0. Codes 2 to 127 are usable.
- R6: With `cfg_enable` at 0, `clk_out` stays 0 and `out_valid` is 0, whatever the divide codes are.
- R7: With `cfg_ext_sel` at 0, the crystal tick is counted and `cfg_pll_sel` has no effect. With `cfg_ext_sel` at 1, `cfg_pll_sel` at 0 selects `tick_pll_a` and at 1 selects `tick_pll_b`.
- R8: While a clock is produced, a change of any setting takes effect only at the end of the current period, after its low phase. The period in progress finishes with the old high and low lengths.
- R9: From idle, a usable setting presented in one cycle makes `clk_out` and `out_valid` both 1 in the next cycle, beginning a high phase.
- R10: When a running clock is given an unusable setting, `out_valid` stays 1 until the current period ends and is 0 from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; all logic is synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| tick_xtal | input | 1 | Half-period strobe of the crystal source |
| tick_pll_a | input | 1 | Half-period strobe of the first PLL |
| tick_pll_b | input | 1 | Half-period strobe of the second PLL |
| cfg_enable | input | 1 | Output enable |
| cfg_pre_code | input | 2 | Predivide code: 0 off, 1/2/3 give 4/5/6 ticks |
| cfg_div_code | input | 7 | Integer divide code, usable from 2 to 127 |
| cfg_ext_sel | input | 1 | 0 selects the crystal, 1 selects a PLL |
| cfg_pll_sel | input | 1 | PLL choice when `cfg_ext_sel` is 1 |
| clk_out | output | 1 | Divided output clock |
| out_valid | output | 1 | The accepted setting produces a clock |

## Verification
The bench sweeps every predivide code over each divide code from 2 to 20 and over the largest code, 127, with the crystal ticking every cycle. The measured high length separates the floor-of-half split for odd codes, and the measured period separates the three predivide steps. The three sources tick every one, two and three cycles, so each select pattern scales the period by a different factor, and a wrong selection shows up as a wrong length. The bench makes changes in the middle of a high phase and compares the lengths of the running period against the new settings, which shows whether the update was held back to the period boundary. The zero and one divide codes, the zero predivide code and a cleared enable are each shown to silence the output.

// File: rtl/hipd_pkg.sv
package hipd_pkg;

  localparam int PRE_W_DEF = 2;
  localparam int DIV_W_DEF = 7;
  localparam int MIN_DIV   = 2;
  localparam int PRE_BASE  = 3;

  typedef enum logic [1:0] {
    SRC_XTAL  = 2'd0,
    SRC_PLL_A = 2'd1,
    SRC_PLL_B = 2'd2
  } src_e;

  // ticks of the doubled source rate consumed per predivided step
  function automatic int pre_ticks(input int code);
    return code + PRE_BASE;
  endfunction

  // integer steps spent in the high phase of one period
  function automatic int high_steps(input int d);
    return d / 2;
  endfunction

  function automatic logic cfg_ok(input logic en, input int pre, input int d);
    return en && (pre != 0) && (d >= MIN_DIV);
  endfunction

  function automatic src_e decode_src(input logic ext, input logic pll);
    if (!ext)     return SRC_XTAL;
    else if (pll) return SRC_PLL_B;
    else          return SRC_PLL_A;
  endfunction

endpackage

// File: rtl/hipd_src_mux.sv
module hipd_src_mux (
  input  hipd_pkg::src_e sel,
  input  logic           tick_xtal,
  input  logic           tick_pll_a,
  input  logic           tick_pll_b,
  output logic           tick
);
  always_comb begin
    case (sel)
      hipd_pkg::SRC_XTAL:  tick = tick_xtal;
      hipd_pkg::SRC_PLL_A: tick = tick_pll_a;
      hipd_pkg::SRC_PLL_B: tick = tick_pll_b;
      default:             tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/hipd_prediv.sv
module hipd_prediv #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] count,
  output logic             pulse
);
  assign pulse = tick && (count == limit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (pulse)  count <= '0;
    else if (tick)   count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/hipd_intdiv.sv
module hipd_intdiv #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  input  logic [DIV_W-1:0] modulus,
  input  logic [DIV_W-1:0] half,
  output logic [DIV_W-1:0] count,
  output logic             wrap,
  output logic             high
);
  assign wrap = step && (count == modulus - DIV_W'(1));
  assign high = (count < half);

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (wrap)   count <= '0;
    else if (step)   count <= count + DIV_W'(1);
  end
endmodule

// File: rtl/hipd_clkgen.sv
module hipd_clkgen #(
  parameter int PRE_W = hipd_pkg::PRE_W_DEF,
  parameter int DIV_W = hipd_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_xtal,
  input  logic             tick_pll_a,
  input  logic             tick_pll_b,
  input  logic             cfg_enable,
  input  logic [PRE_W-1:0] cfg_pre_code,
  input  logic [DIV_W-1:0] cfg_div_code,
  input  logic             cfg_ext_sel,
  input  logic             cfg_pll_sel,
  output logic             clk_out,
  output logic             out_valid
);
  import hipd_pkg::*;

  localparam int PRE_MAX = (1 << PRE_W) - 1 + PRE_BASE;
  localparam int PCNT_W  = $clog2(PRE_MAX + 1);
  localparam int CFG_W   = PRE_W + DIV_W + 3;

  // accepted configuration
  logic             en_q, ext_q, pll_q;
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;

  // named internal events
  logic              load;
  logic              sel_tick;
  logic              pre_pulse;
  logic              period_end;
  logic              phase_high;
  logic [PCNT_W-1:0] pre_lim;
  logic [PCNT_W-1:0] pre_cnt;
  logic [DIV_W-1:0]  half_steps;
  logic [DIV_W-1:0]  div_cnt;
  logic [CFG_W-1:0]  cfg_vec;
  src_e              src_q;

  assign cfg_vec    = {en_q, pre_q, div_q, ext_q, pll_q};
  assign out_valid  = cfg_ok(en_q, int'(pre_q), int'(div_q));
  assign src_q      = decode_src(ext_q, pll_q);
  assign pre_lim    = PCNT_W'(pre_ticks(int'(pre_q)));
  assign half_steps = DIV_W'(high_steps(int'(div_q)));
  assign load       = !out_valid || period_end;
  assign clk_out    = out_valid && phase_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      pre_q <= '0;
      div_q <= '0;
      ext_q <= 1'b0;
      pll_q <= 1'b0;
    end else if (load) begin
      en_q  <= cfg_enable;
      pre_q <= cfg_pre_code;
      div_q <= cfg_div_code;
      ext_q <= cfg_ext_sel;
      pll_q <= cfg_pll_sel;
    end
  end

  hipd_src_mux u_src (
    .sel        (src_q),
    .tick_xtal  (tick_xtal),
    .tick_pll_a (tick_pll_a),
    .tick_pll_b (tick_pll_b),
    .tick       (sel_tick)
  );

  hipd_prediv #(.CNT_W(PCNT_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (load),
    .tick  (sel_tick),
    .limit (pre_lim),
    .count (pre_cnt),
    .pulse (pre_pulse)
  );

  hipd_intdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .step    (pre_pulse),
    .modulus (div_q),
    .half    (half_steps),
    .count   (div_cnt),
    .wrap    (period_end),
    .high    (phase_high)
  );

endmodule

// File: rtl/hipd_clkgen_chk.sv
module hipd_clkgen_chk #(
  parameter int CFG_W  = 12,
  parameter int DIV_W  = 7,
  parameter int PCNT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_out,
  input logic              out_valid,
  input logic [CFG_W-1:0]  cfg_vec,
  input logic [PCNT_W-1:0] pre_cnt,
  input logic [PCNT_W-1:0] pre_lim,
  input logic [DIV_W-1:0]  div_cnt,
  input logic [DIV_W-1:0]  div_mod
);
  // R4 R5 R6: no clock edge without an accepted usable setting
  a_r10_low_when_invalid: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !clk_out);

  // R8: the accepted setting only moves while the output was low
  a_r8_update_after_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_vec) |-> !$past(clk_out));

  // R9: output starts with a high phase
  a_r9_start_high: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> clk_out);

  // R2: counters stay inside the programmed moduli
  a_r2_counts_bounded: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pre_cnt < pre_lim) && (div_cnt < div_mod));

  // R3: every high phase begins at the start of a period
  a_r3_rise_at_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> (pre_cnt == '0) && (div_cnt == '0));
endmodule

bind hipd_clkgen hipd_clkgen_chk #(
  .CFG_W(CFG_W), .DIV_W(DIV_W), .PCNT_W(PCNT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clk_out   (clk_out),
  .out_valid (out_valid),
  .cfg_vec   (cfg_vec),
  .pre_cnt   (pre_cnt),
  .pre_lim   (pre_lim),
  .div_cnt   (div_cnt),
  .div_mod   (div_q)
);

// File: tb/hipd_clkgen_tb.sv
`timescale 1ns/1ps
module hipd_clkgen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_xtal, tick_pll_a, tick_pll_b;
  logic cfg_enable = 1'b0;
  logic [1:0] cfg_pre_code = '0;
  logic [6:0] cfg_div_code = '0;
  logic cfg_ext_sel = 1'b0;
  logic cfg_pll_sel = 1'b0;
  logic clk_out, out_valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int ph = 0;

  always #10 clk = ~clk;

  always @(negedge clk) ph <= (ph == 5) ? 0 : ph + 1;
  assign tick_xtal  = 1'b1;
  assign tick_pll_a = (ph % 2) == 0;
  assign tick_pll_b = (ph % 3) == 0;

  hipd_clkgen u_dut (
    .clk(clk), .rst(rst),
    .tick_xtal(tick_xtal), .tick_pll_a(tick_pll_a), .tick_pll_b(tick_pll_b),
    .cfg_enable(cfg_enable), .cfg_pre_code(cfg_pre_code),
    .cfg_div_code(cfg_div_code), .cfg_ext_sel(cfg_ext_sel),
    .cfg_pll_sel(cfg_pll_sel), .clk_out(clk_out), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int step_ticks(input int code);
    case (code)
      1: return 4;
      2: return 5;
      3: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic set_cfg(input bit en, input int pre, input int d, input bit ext, input bit pll);
    cfg_enable   = en;
    cfg_pre_code = pre[1:0];
    cfg_div_code = d[6:0];
    cfg_ext_sel  = ext;
    cfg_pll_sel  = pll;
  endtask

  task automatic wait_rise(output bit ok);
    bit prev;
    ok = 0;
    prev = clk_out;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (!prev && clk_out) begin ok = 1; break; end
      prev = clk_out;
    end
  endtask

  // counts further samples at level lvl, starting after the current one
  task automatic run_level(input logic lvl, inout int n);
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      if (clk_out !== lvl) break;
      n++;
    end
  endtask

  task automatic measure(input string req, input int pre, input int d, input int k);
    bit ok;
    int hi, lo, exp_hi, exp_per;
    exp_hi  = step_ticks(pre) * (d / 2) * k;
    exp_per = step_ticks(pre) * d * k;
    wait_rise(ok);
    if (ok) wait_rise(ok);
    check(ok, {req, " rise"}, ok, 1);
    if (ok) begin
      hi = 1; run_level(1'b1, hi);
      lo = 1; run_level(1'b0, lo);
      check(hi == exp_hi, {req, " high length"}, hi, exp_hi);
      check(hi + lo == exp_per, {req, " period"}, hi + lo, exp_per);
      check(out_valid == 1'b1, {req, " valid"}, out_valid, 1);
    end
  endtask

  task automatic expect_silent(input string req);
    int highs, valids;
    highs = 0; valids = 0;
    repeat (200) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (clk_out)   highs++;
      if (out_valid) valids++;
    end
    check(highs == 0, {req, " clk_out held low"}, highs, 0);
    check(valids == 0, {req, " out_valid low"}, valids, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int hi, lo, cnt;
    // R1: outputs quiet during reset even with a usable setting present
    set_cfg(1, 1, 4, 0, 0);
    cnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (clk_out || out_valid) cnt++;
    end
    check(cnt == 0, "R1 reset quiet", cnt, 0);
    set_cfg(0, 0, 0, 1, 1);
    @(negedge clk); rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clk_out || out_valid) cnt++;
    end
    check(cnt == 0, "R1 idle after reset", cnt, 0);

    // R9: start from idle in the next cycle with a high phase
    set_cfg(1, 1, 3, 0, 0);
    @(negedge clk);
    check(clk_out == 1'b1, "R9 clk_out starts high", clk_out, 1);
    check(out_valid == 1'b1, "R9 valid starts", out_valid, 1);
    hi = 1; run_level(1'b1, hi);
    check(hi == 4, "R9 R3 first high", hi, 4);

    // R2 R3: sweep of predivide and divide codes on the crystal
    for (int p = 1; p <= 3; p++) begin
      for (int d = 2; d <= 20; d++) begin
        set_cfg(1, p, d, 0, 0);
        measure("R2 R3 sweep", p, d, 1);
      end
      set_cfg(1, p, 127, 0, 0);
      measure("R2 R3 max code", p, 127, 1);
    end

    // R7: source selection; crystal ignores pll select
    set_cfg(1, 2, 3, 0, 1); measure("R7 xtal pll_sel ignored", 2, 3, 1);
    set_cfg(1, 2, 3, 0, 0); measure("R7 xtal", 2, 3, 1);
    set_cfg(1, 2, 3, 1, 0); measure("R7 pll a", 2, 3, 2);
    set_cfg(1, 2, 3, 1, 1); measure("R7 pll b", 2, 3, 3);
    set_cfg(1, 3, 5, 1, 0); measure("R7 pll a odd", 3, 5, 2);
    set_cfg(1, 3, 5, 1, 1); measure("R7 pll b odd", 3, 5, 3);

    // R8: change in mid high phase waits for period end
    set_cfg(1, 1, 10, 0, 0);
    measure("R8 setup", 1, 10, 1);
    wait_rise(ok);
    hi = 1;
    repeat (3) begin @(negedge clk); if (clk_out) hi++; end
    set_cfg(1, 1, 2, 0, 0);
    run_level(1'b1, hi);
    lo = 1; run_level(1'b0, lo);
    check(hi == 20, "R8 old high kept", hi, 20);
    check(lo == 20, "R8 old low kept", lo, 20);
    hi = 1; run_level(1'b1, hi);
    check(hi == 4, "R8 new high", hi, 4);

    // R10: disable mid period, valid holds to period end
    set_cfg(1, 1, 10, 0, 0);
    measure("R10 setup", 1, 10, 1);
    wait_rise(ok);
    hi = 1;
    repeat (3) begin @(negedge clk); if (clk_out) hi++; end
    set_cfg(0, 1, 10, 0, 0);
    run_level(1'b1, hi);
    check(hi == 20, "R10 high completes", hi, 20);
    check(out_valid == 1'b1, "R10 valid in low phase", out_valid, 1);
    repeat (19) @(negedge clk);
    check(out_valid == 1'b1, "R10 valid at last low", out_valid, 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R10 valid drops", out_valid, 0);
    check(clk_out == 1'b0, "R10 output low", clk_out, 0);

    // R4 R5 R6: unusable settings silence the output
    set_cfg(1, 1, 4, 0, 0); repeat (30) @(negedge clk);
    set_cfg(1, 0, 4, 0, 0); expect_silent("R4 pre code 0");
    set_cfg(1, 1, 4, 0, 0); repeat (30) @(negedge clk);
    set_cfg(1, 1, 1, 0, 0); expect_silent("R5 div code 1");
    set_cfg(1, 1, 4, 0, 0); repeat (30) @(negedge clk);
    set_cfg(1, 1, 0, 0, 0); expect_silent("R5 div code 0");
    set_cfg(1, 1, 4, 0, 0); repeat (30) @(negedge clk);
    set_cfg(0, 3, 9, 1, 1); expect_silent("R6 enable clear");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule